// File: doc/BRIEF.md
# Poisoned Packet Error Reporting Unit

This unit reacts to a single-cycle indication that an incoming transaction packet arrived with its poison marker set. From that one event it fans out into several outputs. It may send an upstream error message whose type (fatal or non-fatal) follows a severity setting, provided the matching reporting enable is on. It sets sticky status flags in a device status group, a command status group, and two separately kept "poisoned packet" flags: one in the uncorrectable-error group and one in the interface-error group. It records the packet header into two independent log registers and raises independently masked interrupt sources.

Software clears status by writing ones through a small write port that selects one status group per write. Each log register keeps the header of the first error it records. It does not take a new header until its companion poison flag has been cleared. The interrupt line is a registered OR of the interrupt status bits that are currently unmasked.

Top module: `poison_err_report`

## Requirements
- R1: When a message is sent, `msg_fatal` equals `sev_fatal` as sampled with the error. When no message is sent, `msg_fatal` is 0.
- R2: `msg_req` is a one-cycle pulse at the clock edge that samples `err_pulse`. It occurs only if the enable for the chosen type is set: `rpt_fatal_en` for fatal, `rpt_nonfatal_en` for non-fatal.
- R3: When a message is sent, `dev_sts` sets bit 1 for a fatal message or bit 0 for a non-fatal message. `dev_sts` is unchanged when no message is sent.
- R4: Every error sets both `unc_poison` and `ifc_poison` at the edge that samples it.
- R5: The header is copied into `adv_log` unless `adv_log_mask` is 1, and into `ifc_log` unless `ifc_log_mask` is 1. Each copy is decided on its own.
- R6: While `unc_poison` is set, `adv_log` holds its value. While `ifc_poison` is set, `ifc_log` holds its value.
- R7: `cmd_sts` bit 0 (detected parity) is set on every error. Bit 1 (system error) is set only if `serr_en` is 1. Bit 2 (master data parity) is set only if `err_own_cpl` is 1.
- R8: `irq_sts` has four bits. Bit 0 is the interface error, blocked by `im_ifc`. Bit 1 is the uncorrectable message sent, which needs a sent message and is blocked by `im_unc`. Bit 2 is detected parity, blocked by `im_par`. Bit 3 is master data parity, which needs `err_own_cpl` and is blocked by `im_par`. A mask value of 1 blocks the bit.
- R9: When `clr_en` is high, `clr_sel` picks the group: 0 is `dev_sts`, 1 is `unc_poison`, 2 is `ifc_poison`, 3 is `cmd_sts`, 4 is `irq_sts`. Each 1 in `clr_data` clears the status bit at the same position. The single flags use bit 0. A 0 in `clr_data` leaves its bit unchanged. When a set and a clear hit the same bit in the same cycle, the set wins.
- R10: `irq` is a register that equals the OR of the unmasked `irq_sts` bits, computed on the status state after each edge. A mask change reaches `irq` at the next edge.
- R11: After synchronous reset, all status, log, `msg_req`, `msg_fatal` and `irq` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_pulse | input | 1 | One-cycle poisoned packet indication |
| err_hdr | input | HDR_W | Header of the poisoned packet |
| err_own_cpl | input | 1 | Packet was a completion for a request this device issued |
| sev_fatal | input | 1 | Severity setting: 1 fatal, 0 non-fatal |
| rpt_fatal_en | input | 1 | Fatal message reporting enable |
| rpt_nonfatal_en | input | 1 | Non-fatal message reporting enable |
| serr_en | input | 1 | System error signalling enable |
| im_ifc | input | 1 | Interrupt mask, interface error |
| im_unc | input | 1 | Interrupt mask, uncorrectable message sent |
| im_par | input | 1 | Interrupt mask, both parity interrupts |
| adv_log_mask | input | 1 | Blocks header capture into adv_log |
| ifc_log_mask | input | 1 | Blocks header capture into ifc_log |
| clr_en | input | 1 | Clear write strobe |
| clr_sel | input | 3 | Status group selected for clearing |
| clr_data | input | 4 | Write-one-to-clear data |
| msg_req | output | 1 | Upstream error message request pulse |
| msg_fatal | output | 1 | Type of the requested message |
| irq | output | 1 | Registered interrupt line |
| dev_sts | output | 2 | Bit 1 fatal detected, bit 0 non-fatal detected |
| unc_poison | output | 1 | Poisoned packet flag, uncorrectable-error group |
| ifc_poison | output | 1 | Poisoned packet flag, interface-error group |
| cmd_sts | output | 3 | Bit 2 master data parity, bit 1 system error, bit 0 detected parity |
| irq_sts | output | 4 | Interrupt status bits as in R8 |
| adv_log | output | HDR_W | Advanced-error header log |
| ifc_log | output | HDR_W | Interface-error header log |

## Verification
Corrupted sticky status stays visible on `dev_sts`, `cmd_sts`, `irq_sts` or the poison flags until software clears it, and it shows at the first sample after the faulty edge. An error in the interrupt path shows on `irq` one edge later, because that line is registered. A log register that takes a new header when it should not is caught when a second error carries a different header. A clear decoded to the wrong group is caught by checking that the untouched group keeps its bits. A message gated by the wrong enable shows as a missing or extra `msg_req` pulse in that same cycle.

// File: rtl/poison_pkg.sv
package poison_pkg;

    localparam int N_DEV = 2;
    localparam int N_CMD = 3;
    localparam int N_IRQ = 4;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        GRP_DEV = 3'd0,
        GRP_UNC = 3'd1,
        GRP_IFC = 3'd2,
        GRP_CMD = 3'd3,
        GRP_IRQ = 3'd4
    } grp_sel_e;

    typedef struct packed {
        logic send;
        logic fatal;
    } msg_t;

    typedef struct packed {
        logic [N_IRQ-1:0] irq;
        logic [N_CMD-1:0] cmd;
        logic             ifc;
        logic             unc;
        logic [N_DEV-1:0] dev;
    } sts_vec_t;

    function automatic msg_t pick_msg(input logic sev, input logic fat_en, input logic nf_en);
        msg_t m;
        m.fatal = sev;
        m.send  = sev ? fat_en : nf_en;
        return m;
    endfunction

    function automatic logic [N_IRQ-1:0] irq_enables(input logic m_ifc, input logic m_unc,
                                                     input logic m_par);
        return {~m_par, ~m_par, ~m_unc, ~m_ifc};
    endfunction

endpackage

// File: rtl/poison_sticky.sv
module poison_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] d_o
);
    logic [W-1:0] q;

    always_comb d_o = (q & ~clr_i) | set_i;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d_o;
    end

    assign q_o = q;
endmodule

// File: rtl/poison_msg_gen.sv
module poison_msg_gen
    import poison_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic err_i,
    input  logic sev_i,
    input  logic fat_en_i,
    input  logic nf_en_i,
    output logic send_now_o,
    output logic fatal_now_o,
    output logic req_o,
    output logic fatal_o
);
    msg_t m;

    always_comb begin
        m           = pick_msg(sev_i, fat_en_i, nf_en_i);
        send_now_o  = err_i & m.send;
        fatal_now_o = m.fatal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o   <= 1'b0;
            fatal_o <= 1'b0;
        end else begin
            req_o   <= send_now_o;
            fatal_o <= send_now_o & m.fatal;
        end
    end
endmodule

// File: rtl/poison_hdr_log.sv
module poison_hdr_log #(
    parameter int HDR_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_i,
    input  logic [HDR_W-1:0] hdr_i,
    output logic [HDR_W-1:0] log_o
);
    always_ff @(posedge clk) begin
        if (rst)        log_o <= '0;
        else if (cap_i) log_o <= hdr_i;
    end
endmodule

// File: rtl/poison_err_report.sv
module poison_err_report
    import poison_pkg::*;
#(
    parameter int HDR_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_pulse,
    input  logic [HDR_W-1:0] err_hdr,
    input  logic             err_own_cpl,
    input  logic             sev_fatal,
    input  logic             rpt_fatal_en,
    input  logic             rpt_nonfatal_en,
    input  logic             serr_en,
    input  logic             im_ifc,
    input  logic             im_unc,
    input  logic             im_par,
    input  logic             adv_log_mask,
    input  logic             ifc_log_mask,
    input  logic             clr_en,
    input  logic [SEL_W-1:0] clr_sel,
    input  logic [N_IRQ-1:0] clr_data,
    output logic             msg_req,
    output logic             msg_fatal,
    output logic             irq,
    output logic [N_DEV-1:0] dev_sts,
    output logic             unc_poison,
    output logic             ifc_poison,
    output logic [N_CMD-1:0] cmd_sts,
    output logic [N_IRQ-1:0] irq_sts,
    output logic [HDR_W-1:0] adv_log,
    output logic [HDR_W-1:0] ifc_log
);
    localparam int STS_W = $bits(sts_vec_t);
    localparam int N_LOG = 2;

    logic             send_now, fatal_now;
    logic [N_IRQ-1:0] irq_en, irq_src;
    sts_vec_t         set_v, clr_v, sts_q, sts_d;
    logic             irq_q;

    poison_msg_gen u_msg (
        .clk        (clk),
        .rst        (rst),
        .err_i      (err_pulse),
        .sev_i      (sev_fatal),
        .fat_en_i   (rpt_fatal_en),
        .nf_en_i    (rpt_nonfatal_en),
        .send_now_o (send_now),
        .fatal_now_o(fatal_now),
        .req_o      (msg_req),
        .fatal_o    (msg_fatal)
    );

    // Set vector: one error fans out to every status group
    always_comb begin
        irq_en    = irq_enables(im_ifc, im_unc, im_par);
        irq_src   = {err_own_cpl, 1'b1, send_now, 1'b1} & {N_IRQ{err_pulse}};
        set_v     = '0;
        set_v.dev = send_now ? (fatal_now ? 2'b10 : 2'b01) : 2'b00;
        set_v.unc = err_pulse;
        set_v.ifc = err_pulse;
        set_v.cmd = {err_own_cpl, serr_en, 1'b1} & {N_CMD{err_pulse}};
        set_v.irq = irq_src & irq_en;
    end

    // Write-one-to-clear decode, one group per write
    always_comb begin
        clr_v = '0;
        if (clr_en) begin
            case (grp_sel_e'(clr_sel))
                GRP_DEV: clr_v.dev = clr_data[N_DEV-1:0];
                GRP_UNC: clr_v.unc = clr_data[0];
                GRP_IFC: clr_v.ifc = clr_data[0];
                GRP_CMD: clr_v.cmd = clr_data[N_CMD-1:0];
                GRP_IRQ: clr_v.irq = clr_data;
                default: clr_v = '0;
            endcase
        end
    end

    logic [STS_W-1:0] sts_q_raw, sts_d_raw;

    poison_sticky #(.W(STS_W)) u_sts (
        .clk  (clk),
        .rst  (rst),
        .set_i(set_v),
        .clr_i(clr_v),
        .q_o  (sts_q_raw),
        .d_o  (sts_d_raw)
    );

    assign sts_q = sts_vec_t'(sts_q_raw);
    assign sts_d = sts_vec_t'(sts_d_raw);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(sts_d.irq & irq_en);
    end

    // Two header logs, each frozen while its poison flag is set
    logic [N_LOG-1:0] log_ok;
    logic [HDR_W-1:0] log_q [N_LOG];

    assign log_ok[0] = ~adv_log_mask & ~sts_q.unc;
    assign log_ok[1] = ~ifc_log_mask & ~sts_q.ifc;

    for (genvar g = 0; g < N_LOG; g++) begin : g_log
        poison_hdr_log #(.HDR_W(HDR_W)) u_log (
            .clk  (clk),
            .rst  (rst),
            .cap_i(err_pulse & log_ok[g]),
            .hdr_i(err_hdr),
            .log_o(log_q[g])
        );
    end

    assign adv_log    = log_q[0];
    assign ifc_log    = log_q[1];
    assign dev_sts    = sts_q.dev;
    assign unc_poison = sts_q.unc;
    assign ifc_poison = sts_q.ifc;
    assign cmd_sts    = sts_q.cmd;
    assign irq_sts    = sts_q.irq;
    assign irq        = irq_q;
endmodule

// File: rtl/poison_err_report_chk.sv
module poison_err_report_chk #(
    parameter int HDR_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             err_pulse,
    input logic             err_own_cpl,
    input logic             sev_fatal,
    input logic             rpt_fatal_en,
    input logic             rpt_nonfatal_en,
    input logic             serr_en,
    input logic             msg_req,
    input logic             msg_fatal,
    input logic             irq,
    input logic [1:0]       dev_sts,
    input logic             unc_poison,
    input logic             ifc_poison,
    input logic [2:0]       cmd_sts,
    input logic [3:0]       irq_sts,
    input logic [HDR_W-1:0] adv_log,
    input logic [HDR_W-1:0] ifc_log
);
    p_msg_type_r1: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> (msg_fatal == $past(sev_fatal)));

    p_msg_gate_r2: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> ($past(err_pulse) &&
                     ($past(sev_fatal) ? $past(rpt_fatal_en) : $past(rpt_nonfatal_en))));

    p_dev_match_r3: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> (msg_fatal ? dev_sts[1] : dev_sts[0]));

    p_mirror_r4: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> (unc_poison && ifc_poison));

    p_adv_hold_r6: assert property (@(posedge clk) disable iff (rst)
        unc_poison |=> $stable(adv_log));

    p_ifc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ifc_poison |=> $stable(ifc_log));

    p_serr_gate_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_sts[1]) |-> $past(serr_en));

    p_mdp_gate_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_sts[2]) |-> $past(err_own_cpl));

    p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_sts != 4'b0000));
endmodule

bind poison_err_report poison_err_report_chk #(.HDR_W(HDR_W)) u_chk (.*);

// File: tb/poison_err_report_tb.sv
`timescale 1ns/1ps
module poison_err_report_tb;
    localparam int HDR_W = 128;

    logic clk = 1'b0;
    logic rst;
    logic err_pulse, err_own_cpl, sev_fatal, rpt_fatal_en, rpt_nonfatal_en, serr_en;
    logic im_ifc, im_unc, im_par, adv_log_mask, ifc_log_mask, clr_en;
    logic [HDR_W-1:0] err_hdr;
    logic [2:0] clr_sel;
    logic [3:0] clr_data;
    logic msg_req, msg_fatal, irq, unc_poison, ifc_poison;
    logic [1:0] dev_sts;
    logic [2:0] cmd_sts;
    logic [3:0] irq_sts;
    logic [HDR_W-1:0] adv_log, ifc_log;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    poison_err_report #(.HDR_W(HDR_W)) u_dut (.*);

    // {sev, fat_en, nf_en, serr, own, im_ifc, im_unc, im_par, msg, fatal, dev[1:0], cmd[2:0], irq[3:0]}
    localparam logic [18:0] VEC [6] = '{
        19'b1_1_0_1_0_0_0_0_1_1_10_011_0111,
        19'b0_1_1_0_1_0_0_0_1_0_01_101_1111,
        19'b1_0_1_0_0_0_0_0_0_0_00_001_0101,
        19'b0_1_0_1_1_1_1_1_0_0_00_111_0000,
        19'b0_0_1_0_1_1_0_0_1_0_01_101_1110,
        19'b1_1_0_0_1_0_1_1_1_1_10_101_0001
    };

    task automatic chk(input string req, input logic [HDR_W-1:0] act, input logic [HDR_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; err_pulse = 0; err_own_cpl = 0; sev_fatal = 0; rpt_fatal_en = 0;
        rpt_nonfatal_en = 0; serr_en = 0; im_ifc = 0; im_unc = 0; im_par = 0;
        adv_log_mask = 0; ifc_log_mask = 0; clr_en = 0; clr_sel = 0; clr_data = 0; err_hdr = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(input logic [HDR_W-1:0] h);
        err_hdr = h; err_pulse = 1'b1;
        @(negedge clk);
        err_pulse = 1'b0;
    endtask

    task automatic clear(input logic [2:0] sel, input logic [3:0] d);
        clr_en = 1'b1; clr_sel = sel; clr_data = d;
        @(negedge clk);
        clr_en = 1'b0; clr_data = '0;
    endtask

    localparam logic [HDR_W-1:0] HA = {4{32'hA5A5_0001}};
    localparam logic [HDR_W-1:0] HB = {4{32'h3C3C_0002}};
    localparam logic [HDR_W-1:0] HC = {4{32'h0F0F_0003}};

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        chk("R11 msg_req", msg_req, 0);
        chk("R11 irq", irq, 0);
        chk("R11 status", {dev_sts, unc_poison, ifc_poison, cmd_sts, irq_sts}, 0);
        chk("R11 adv_log", adv_log, 0);
        chk("R11 ifc_log", ifc_log, 0);

        // Table walk: R1 R2 R3 R4 R7 R8 R10
        for (int i = 0; i < 6; i++) begin
            do_reset();
            {sev_fatal, rpt_fatal_en, rpt_nonfatal_en, serr_en, err_own_cpl,
             im_ifc, im_unc, im_par} = VEC[i][18:11];
            pulse(HA);
            chk("R2 msg_req", msg_req, VEC[i][10]);
            chk("R1 msg_fatal", msg_fatal, VEC[i][9]);
            chk("R3 dev_sts", dev_sts, VEC[i][8:7]);
            chk("R7 cmd_sts", cmd_sts, VEC[i][6:4]);
            chk("R8 irq_sts", irq_sts, VEC[i][3:0]);
            chk("R10 irq", irq, |VEC[i][3:0]);
            chk("R4 both poison flags", {unc_poison, ifc_poison}, 2'b11);
            @(negedge clk);
            chk("R2 msg_req one cycle", msg_req, 0);
        end

        // R5 R6 log capture and hold, R9 per-group clear
        do_reset();
        sev_fatal = 1; rpt_fatal_en = 1;
        pulse(HA);
        chk("R5 adv_log capture", adv_log, HA);
        chk("R5 ifc_log capture", ifc_log, HA);
        pulse(HB);
        chk("R6 adv_log held", adv_log, HA);
        chk("R6 ifc_log held", ifc_log, HA);
        clear(3'd1, 4'b0001);
        chk("R9 unc cleared", unc_poison, 0);
        chk("R9 ifc untouched", ifc_poison, 1);
        pulse(HB);
        chk("R6 adv_log after clear", adv_log, HB);
        chk("R6 ifc_log still first", ifc_log, HA);

        // R9 set wins over clear in the same cycle
        clr_en = 1; clr_sel = 3'd1; clr_data = 4'b0001;
        pulse(HC);
        clr_en = 0; clr_data = 0;
        chk("R9 set wins", unc_poison, 1);

        // R9 zero bits do not clear; one bits clear
        chk("R3 dev fatal set", dev_sts, 2'b10);
        clear(3'd0, 4'b0001);
        chk("R9 zero bit keeps", dev_sts, 2'b10);
        clear(3'd0, 4'b0010);
        chk("R9 one bit clears", dev_sts, 2'b00);
        chk("R9 cmd untouched", cmd_sts, 3'b001);

        // R5 log mask per log
        do_reset();
        adv_log_mask = 1;
        pulse(HC);
        chk("R5 adv_log masked", adv_log, 0);
        chk("R5 ifc_log unmasked", ifc_log, HC);

        // R10 mask change reaches irq one edge later; R8/R9 irq clear
        do_reset();
        pulse(HA);
        chk("R8 irq_sts no msg", irq_sts, 4'b0101);
        chk("R10 irq set", irq, 1);
        im_ifc = 1; im_par = 1;
        @(negedge clk);
        chk("R10 irq masked", irq, 0);
        chk("R10 status kept", irq_sts, 4'b0101);
        im_ifc = 0; im_par = 0;
        @(negedge clk);
        chk("R10 irq unmasked", irq, 1);
        clear(3'd4, 4'b0101);
        chk("R9 irq_sts cleared", irq_sts, 0);
        chk("R10 irq after clear", irq, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule